// File: doc/BRIEF.md
# Per-Thread First-Error Status Capture

This block records disrupting hardware errors for a group of hardware threads. Each thread owns a status record that keeps the first error it sees: an error type code, an error address, a "full" indication and a status bit. Any error that arrives while the record is already full is not stored. It only raises an overflow flag, so the first error is never overwritten. Software empties a thread's record through a per-thread clear input.

Next to the per-thread records, the block keeps two core-wide views, each 64 bits wide. The summary view mirrors every thread's full indication at a fixed bit position. The first-error view latches a thread's bit the moment that thread reports, and keeps it after the thread's record is cleared. The first-error view is wiped only when a clear leaves the whole summary empty, so software can tell which threads took part in an error burst.

Error detection and trap delivery sit outside this block. It only sees a report strobe that carries a thread number, a type code and an address.

Top module: `errcap_top`

## Requirements
- R1: After reset every thread record reads empty: full, overflow, status bit, type and address are all 0. Summary and first-error views are 0.
- R2: A report to a thread whose full flag is 0 sets full to 1 and clears the status bit. In the next cycle it shows the reported type and address.
- R3: A report to a thread whose full flag is already 1 sets its overflow flag. Full, type and address keep their previous values.
- R4: Thread t's full flag appears at summary bit 48 + 2*t + 1, so eight threads occupy the odd positions 49 to 63. Every other summary bit reads 0.
- R5: A report to thread t sets first-error bit 48 + 2*t + 1. That bit stays set after the thread is cleared, as long as any summary bit is still 1.
- R6: A clear of thread t, with no report to t in the same cycle, zeroes all of t's record fields and its summary bit in the next cycle.
- R7: When a clear leaves the summary view at all zeros, the first-error view becomes all zeros in the same update.
- R8: A report and a clear aimed at the same thread in the same cycle act as the report alone. The clear has no effect on that thread.
- R9: A report changes only the addressed thread's record, and a clear changes only the selected threads' records. Several threads may be cleared in one cycle while another thread reports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rpt_vld | input | 1 | Error report strobe |
| rpt_thr | input | 3 | Thread number of the report |
| rpt_type | input | 4 | Error type code of the report |
| rpt_addr | input | 10 | Error address of the report |
| clr | input | 8 | Per-thread software clear |
| thr_full | output | 8 | Per-thread full flag |
| thr_multi | output | 8 | Per-thread overflow flag |
| thr_flag | output | 8 | Per-thread status bit |
| thr_type | output | 32 | Per-thread error type, thread t at bits 4t+3..4t |
| thr_addr | output | 80 | Per-thread error address, thread t at bits 10t+9..10t |
| summary | output | 64 | Core summary view |
| first_err | output | 64 | Sticky first-error view |

## Verification
The bench fills each thread in turn with a distinct type and address, which separates a correct capture from one that writes the wrong thread or the wrong bit position. It then reports to every thread a second time with different values; this shows whether overflow leaves the first capture intact. Clears are applied one thread at a time, and the bench watches the first-error view stay unchanged until the last clear empties the summary. A sweep of several hundred cycles then combines reports with no clear, one-hot clears, clear-all, and clear-all-but-the-reporter. These patterns separate same-cycle priority, multi-thread clears and the conditional wipe of the first-error view.

// File: rtl/errcap_pkg.sv
package errcap_pkg;

  // Slot of this status register inside each thread's pair of summary bits
  localparam int unsigned LANE_OFS = 1;

  // Summary / first-error bit position owned by a thread
  function automatic int unsigned sum_pos(input int unsigned base, input int unsigned thr);
    return base + 2 * thr + LANE_OFS;
  endfunction

  // What a thread record does in a given cycle
  typedef enum logic [1:0] {
    EV_NONE     = 2'd0,
    EV_CAPTURE  = 2'd1,
    EV_OVERFLOW = 2'd2,
    EV_WIPE     = 2'd3
  } thr_ev_e;

endpackage

// File: rtl/errcap_thread.sv
module errcap_thread
  import errcap_pkg::*;
#(
  parameter int unsigned TYPE_W = 4,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rpt_hit,
  input  logic              clr_hit,
  input  logic [TYPE_W-1:0] rpt_type,
  input  logic [ADDR_W-1:0] rpt_addr,
  output logic              full,
  output logic              multi,
  output logic              flag,
  output logic [TYPE_W-1:0] etype,
  output logic [ADDR_W-1:0] eaddr,
  output thr_ev_e           ev
);

  // Event decode: a report outranks a clear aimed at the same thread
  always_comb begin
    if (rpt_hit)      ev = full ? EV_OVERFLOW : EV_CAPTURE;
    else if (clr_hit) ev = EV_WIPE;
    else              ev = EV_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full  <= 1'b0;
      multi <= 1'b0;
      flag  <= 1'b0;
      etype <= '0;
      eaddr <= '0;
    end else begin
      unique case (ev)
        EV_CAPTURE: begin
          full  <= 1'b1;
          flag  <= 1'b0;
          etype <= rpt_type;
          eaddr <= rpt_addr;
        end
        EV_OVERFLOW: multi <= 1'b1;
        EV_WIPE: begin
          full  <= 1'b0;
          multi <= 1'b0;
          flag  <= 1'b0;
          etype <= '0;
          eaddr <= '0;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/errcap_summary.sv
module errcap_summary
  import errcap_pkg::*;
#(
  parameter int unsigned NUM_THR  = 8,
  parameter int unsigned SUM_W    = 64,
  parameter int unsigned SUM_BASE = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_THR-1:0] set_vec,
  input  logic [NUM_THR-1:0] wipe_vec,
  output logic [SUM_W-1:0]   summary,
  output logic [SUM_W-1:0]   first_err,
  output logic               fe_wipe
);

  logic [NUM_THR-1:0] sum_q, sum_d;
  logic [NUM_THR-1:0] fe_q, fe_d;

  // A written value of 1 sets the bit (and its first-error copy if clear);
  // a written value of 0 clears it and may wipe the first-error view
  always_comb begin
    sum_d   = (sum_q & ~wipe_vec) | set_vec;
    fe_wipe = (|wipe_vec) && (sum_d == '0);
    fe_d    = fe_wipe ? '0 : (fe_q | set_vec);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q <= '0;
      fe_q  <= '0;
    end else begin
      sum_q <= sum_d;
      fe_q  <= fe_d;
    end
  end

  // Spread the per-thread bits onto their positions in the wide views
  always_comb begin
    summary   = '0;
    first_err = '0;
    for (int unsigned t = 0; t < NUM_THR; t++) begin
      summary[sum_pos(SUM_BASE, t)]   = sum_q[t];
      first_err[sum_pos(SUM_BASE, t)] = fe_q[t];
    end
  end

endmodule

// File: rtl/errcap_top.sv
module errcap_top
  import errcap_pkg::*;
#(
  parameter int unsigned NUM_THR  = 8,
  parameter int unsigned TYPE_W   = 4,
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned SUM_W    = 64,
  parameter int unsigned SUM_BASE = 48,
  localparam int unsigned THR_W   = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rpt_vld,
  input  logic [THR_W-1:0]          rpt_thr,
  input  logic [TYPE_W-1:0]         rpt_type,
  input  logic [ADDR_W-1:0]         rpt_addr,
  input  logic [NUM_THR-1:0]        clr,
  output logic [NUM_THR-1:0]        thr_full,
  output logic [NUM_THR-1:0]        thr_multi,
  output logic [NUM_THR-1:0]        thr_flag,
  output logic [NUM_THR*TYPE_W-1:0] thr_type,
  output logic [NUM_THR*ADDR_W-1:0] thr_addr,
  output logic [SUM_W-1:0]          summary,
  output logic [SUM_W-1:0]          first_err
);

  // Named internal events, visible to the checker
  logic [NUM_THR-1:0] rpt_onehot;
  logic [NUM_THR-1:0] set_vec;
  logic [NUM_THR-1:0] wipe_vec;
  logic               fe_wipe;
  thr_ev_e            thr_ev [NUM_THR];

  assign rpt_onehot = rpt_vld ? (NUM_THR'(1) << rpt_thr) : '0;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    errcap_thread #(
      .TYPE_W (TYPE_W),
      .ADDR_W (ADDR_W)
    ) u_thr (
      .clk      (clk),
      .rst_n    (rst_n),
      .rpt_hit  (rpt_onehot[t]),
      .clr_hit  (clr[t]),
      .rpt_type (rpt_type),
      .rpt_addr (rpt_addr),
      .full     (thr_full[t]),
      .multi    (thr_multi[t]),
      .flag     (thr_flag[t]),
      .etype    (thr_type[t*TYPE_W +: TYPE_W]),
      .eaddr    (thr_addr[t*ADDR_W +: ADDR_W]),
      .ev       (thr_ev[t])
    );
    assign set_vec[t]  = (thr_ev[t] == EV_CAPTURE) || (thr_ev[t] == EV_OVERFLOW);
    assign wipe_vec[t] = (thr_ev[t] == EV_WIPE);
  end

  errcap_summary #(
    .NUM_THR  (NUM_THR),
    .SUM_W    (SUM_W),
    .SUM_BASE (SUM_BASE)
  ) u_sum (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vec   (set_vec),
    .wipe_vec  (wipe_vec),
    .summary   (summary),
    .first_err (first_err),
    .fe_wipe   (fe_wipe)
  );

endmodule

// File: rtl/errcap_chk.sv
module errcap_chk
  import errcap_pkg::*;
#(
  parameter int unsigned NUM_THR  = 8,
  parameter int unsigned TYPE_W   = 4,
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned SUM_W    = 64,
  parameter int unsigned SUM_BASE = 48,
  localparam int unsigned THR_W   = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      rpt_vld,
  input logic [THR_W-1:0]          rpt_thr,
  input logic [TYPE_W-1:0]         rpt_type,
  input logic [ADDR_W-1:0]         rpt_addr,
  input logic [NUM_THR-1:0]        clr,
  input logic [NUM_THR-1:0]        thr_full,
  input logic [NUM_THR-1:0]        thr_multi,
  input logic [NUM_THR*TYPE_W-1:0] thr_type,
  input logic [NUM_THR*ADDR_W-1:0] thr_addr,
  input logic [SUM_W-1:0]          summary,
  input logic [SUM_W-1:0]          first_err
);

  logic [SUM_W-1:0] lane_mask;
  always_comb begin
    lane_mask = '0;
    for (int unsigned t = 0; t < NUM_THR; t++) lane_mask[sum_pos(SUM_BASE, t)] = 1'b1;
  end

  // R4
  unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (summary & ~lane_mask) == '0);

  // R5
  fe_covers_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (first_err & summary) == summary);

  // R7
  fe_empty_with_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (summary == '0) |-> (first_err == '0));

  for (genvar t = 0; t < NUM_THR; t++) begin : g_t
    // R4
    sum_mirrors_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      summary[sum_pos(SUM_BASE, t)] == thr_full[t]);

    // R2
    first_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rpt_vld && rpt_thr == THR_W'(t) && !thr_full[t]) |=>
        (thr_full[t] && thr_type[t*TYPE_W +: TYPE_W] == $past(rpt_type)
                     && thr_addr[t*ADDR_W +: ADDR_W] == $past(rpt_addr)));

    // R3
    overflow_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rpt_vld && rpt_thr == THR_W'(t) && thr_full[t]) |=>
        (thr_multi[t] && $stable(thr_type[t*TYPE_W +: TYPE_W])
                      && $stable(thr_addr[t*ADDR_W +: ADDR_W])));

    // R6
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[t] && !(rpt_vld && rpt_thr == THR_W'(t))) |=> (!thr_full[t] && !thr_multi[t]));

    // R8
    report_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[t] && rpt_vld && rpt_thr == THR_W'(t)) |=> thr_full[t]);
  end

endmodule

bind errcap_top errcap_chk #(
  .NUM_THR  (NUM_THR),
  .TYPE_W   (TYPE_W),
  .ADDR_W   (ADDR_W),
  .SUM_W    (SUM_W),
  .SUM_BASE (SUM_BASE)
) u_chk (.*);

// File: tb/test_errcap_top.sv
module test_errcap_top;

  localparam int CLK_PERIOD = 10;
  localparam int NT = 8;
  localparam int TW = 4;
  localparam int AW = 10;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            rpt_vld;
  logic [2:0]      rpt_thr;
  logic [TW-1:0]   rpt_type;
  logic [AW-1:0]   rpt_addr;
  logic [NT-1:0]   clr;
  logic [NT-1:0]   thr_full, thr_multi, thr_flag;
  logic [NT*TW-1:0] thr_type;
  logic [NT*AW-1:0] thr_addr;
  logic [63:0]     summary, first_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  errcap_top i_errcap_top (
    .clk, .rst_n, .rpt_vld, .rpt_thr, .rpt_type, .rpt_addr, .clr,
    .thr_full, .thr_multi, .thr_flag, .thr_type, .thr_addr, .summary, .first_err
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // Reference state written from the requirements
  bit          m_full  [NT];
  bit          m_multi [NT];
  logic [TW-1:0] m_type [NT];
  logic [AW-1:0] m_addr [NT];
  logic [63:0] m_fe;

  function automatic logic [63:0] m_sum();
    logic [63:0] s = '0;
    for (int t = 0; t < NT; t++) if (m_full[t]) s[49 + 2*t] = 1'b1;
    return s;
  endfunction

  task automatic cmp(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int t = 0; t < NT; t++) begin
      cmp(req, $sformatf("full[%0d]", t),  64'(thr_full[t]),  64'(m_full[t]));
      cmp(req, $sformatf("multi[%0d]", t), 64'(thr_multi[t]), 64'(m_multi[t]));
      cmp(req, $sformatf("flag[%0d]", t),  64'(thr_flag[t]),  64'd0);
      cmp(req, $sformatf("type[%0d]", t),  64'(thr_type[t*TW +: TW]), 64'(m_type[t]));
      cmp(req, $sformatf("addr[%0d]", t),  64'(thr_addr[t*AW +: AW]), 64'(m_addr[t]));
    end
    cmp(req, "summary", summary, m_sum());
    cmp(req, "first_err", first_err, m_fe);
  endtask

  // Called at a falling edge; checks at the next falling edge
  task automatic step(input bit rv, input int rt, input logic [TW-1:0] ty,
                      input logic [AW-1:0] ad, input logic [NT-1:0] cm, input string req);
    bit any_wipe;
    any_wipe = 0;
    rpt_vld  = rv;
    rpt_thr  = rt[2:0];
    rpt_type = ty;
    rpt_addr = ad;
    clr      = cm;
    for (int t = 0; t < NT; t++) begin
      if (rv && rt == t) begin
        if (!m_full[t]) begin
          m_full[t] = 1; m_type[t] = ty; m_addr[t] = ad;
        end else m_multi[t] = 1;
      end else if (cm[t]) begin
        m_full[t] = 0; m_multi[t] = 0; m_type[t] = '0; m_addr[t] = '0;
        any_wipe = 1;
      end
    end
    if (rv) m_fe[49 + 2*rt] = 1'b1;
    if (any_wipe && m_sum() == 64'd0) m_fe = '0;
    @(negedge clk);
    rpt_vld = 0;
    clr     = '0;
    check_all(req);
  endtask

  initial begin
    rst_n = 0; rpt_vld = 0; rpt_thr = '0; rpt_type = '0; rpt_addr = '0; clr = '0;
    for (int t = 0; t < NT; t++) begin
      m_full[t] = 0; m_multi[t] = 0; m_type[t] = '0; m_addr[t] = '0;
    end
    m_fe = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1");

    // First capture in each thread, others must stay untouched
    for (int t = 0; t < NT; t++)
      step(1, t, TW'(t*3 + 1), AW'(t*71 + 9), '0, "R2/R4/R5/R9");

    // Second report to each thread: overflow only
    for (int t = 0; t < NT; t++)
      step(1, t, TW'(~(t*3 + 1)), AW'(t*5 + 600), '0, "R3/R9");

    // Clear threads one by one: first-error holds until the last one
    for (int t = 0; t < NT - 1; t++)
      step(0, 0, '0, '0, NT'(1) << t, "R5/R6");
    step(0, 0, '0, '0, NT'(1) << (NT - 1), "R7");

    // Report and clear to the same thread in one cycle
    step(1, 2, 4'hA, 10'h155, 8'h24, "R8/R9");
    step(1, 2, 4'h3, 10'h0AA, 8'h04, "R8/R3");
    // Clear of an empty thread while summary is nonzero keeps first-error
    step(0, 0, '0, '0, 8'h01, "R5/R6");
    // Report elsewhere while clearing several threads
    step(1, 6, 4'h7, 10'h3C3, 8'h0C, "R9/R7");
    step(0, 0, '0, '0, 8'h40, "R7");

    // Near-exhaustive sweep over report thread and clear patterns
    for (int k = 0; k < 512; k++) begin
      logic [NT-1:0] cm;
      bit rv;
      int rt;
      rv = (k % 2 == 1) || ((k / 32) % 2 == 1);
      rt = (k / 2) % 8;
      case ((k / 64) % 4)
        0: cm = '0;
        1: cm = NT'(1) << ((k / 8) % 8);
        2: cm = '1;
        default: cm = ~(NT'(1) << rt);
      endcase
      step(rv, rt, TW'(k ^ (k / 16)), AW'(k * 13), cm, "R2/R3/R6/R7/R8/R9");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule